// File: doc/BRIEF.md
# Signed ALU with Condition Flags

This block is the arithmetic and logic stage of a small load/store processor. It receives two 64-bit register operands, called A (the source) and B (the destination), plus a 2-bit function code, and returns the value that will overwrite the destination register. Four operations are available: addition, subtraction (B minus A), bitwise AND and bitwise XOR. The result path has no registers, so the value is valid in the same cycle as the operands.

Next to the datapath is a small condition-code register with three flags: zero, sign and signed overflow. It is loaded on a rising clock edge only when the update strobe is high. A decoder raises the strobe for ALU instructions only, so moves and branches leave the flags as they were. All values are treated as signed two's complement. There is no carry flag and no unsigned mode.

Subtraction reuses the adder. The source operand is inverted and a carry of one is injected at bit 0. Overflow is the exclusive OR of the carry entering the top bit and the carry leaving it.

Top module: `flag_alu`

## Requirements
- R1: With function code 2'b00, `result` equals `opnd_b + opnd_a` modulo 2^64, in the same cycle as the inputs.
- R2: With function code 2'b01, `result` equals `opnd_b - opnd_a` modulo 2^64.
- R3: With function code 2'b10, `result` is `opnd_b & opnd_a`. With 2'b11, it is `opnd_b ^ opnd_a`.
- R4: After a rising edge with `alu_en` high, `flag_z` is 1 exactly when all 64 bits of the result in that cycle were 0.
- R5: After a rising edge with `alu_en` high, `flag_s` equals bit 63 of the result in that cycle.
- R6: After a rising edge with `alu_en` high and an add or subtract selected, `flag_o` is 1 exactly when the signed result does not fit in 64 bits. That is the case when the carry into bit 63 differs from the carry out of bit 63.
- R7: After a rising edge with `alu_en` high and AND or XOR selected, `flag_o` is 0.
- R8: A rising edge with `alu_en` low leaves all three flags unchanged, whatever the operands and function code are.
- R9: A rising edge with `rst` high (synchronous, active high) sets `flag_z`=1, `flag_s`=0 and `flag_o`=0. Reset takes priority over `alu_en`.
- R10: The flags change only on a clock edge. Between the strobe and the next rising edge they still show the previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags load on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| alu_en | input | 1 | Update strobe; high for an ALU instruction |
| fn_sel | input | 2 | 00 add, 01 subtract, 10 AND, 11 XOR |
| opnd_a | input | 64 | Source operand A |
| opnd_b | input | 64 | Destination operand B (left-hand side) |
| result | output | 64 | Combinational result, B op A |
| flag_z | output | 1 | Registered zero flag |
| flag_s | output | 1 | Registered sign flag |
| flag_o | output | 1 | Registered signed-overflow flag |

## Verification
The embedded assertions check the following on every cycle:
- the arithmetic identities of add and subtract at the ports,
- that the zero and sign flags follow the previous cycle's result,
- the sign-based overflow rule for add and subtract,
- that the flags hold when the strobe is low, and the reset values.

Some behaviour only the bench's scenarios can show, by setting up an earlier state and then reading the ports:
- that an edge with the strobe low really preserves a set overflow or sign flag left by an earlier instruction;
- that the flags stay old before the edge;
- the extreme cases: most-positive plus one, most-negative minus one, zero minus most-negative, and the case where the carry out is 1 but no overflow occurs.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  localparam int DATA_W = 64;

  typedef enum logic [1:0] {
    FN_ADD = 2'b00,
    FN_SUB = 2'b01,
    FN_AND = 2'b10,
    FN_XOR = 2'b11
  } alu_fn_e;
endpackage

// File: rtl/flag_alu_adder.sv
module flag_alu_adder #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf
);
  localparam int LOW_W = W - 1;

  logic [W-1:0]     a_eff;
  logic [LOW_W-1:0] low_sum;
  logic             c_into_top;
  logic             c_out_top;
  logic             top_bit;

  // subtract: invert source and inject a carry at bit 0
  assign a_eff = a_in ^ {W{sub}};

  assign {c_into_top, low_sum} = {1'b0, b_in[LOW_W-1:0]}
                               + {1'b0, a_eff[LOW_W-1:0]}
                               + {{LOW_W{1'b0}}, sub};

  assign {c_out_top, top_bit} = {1'b0, b_in[W-1]}
                              + {1'b0, a_eff[W-1]}
                              + {1'b0, c_into_top};

  assign sum = {top_bit, low_sum};
  assign ovf = c_into_top ^ c_out_top;
endmodule

// File: rtl/flag_alu_flags.sv
module flag_alu_flags #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic         arith,
  input  logic         ovf_raw,
  input  logic [W-1:0] res,
  output logic         zf,
  output logic         sf,
  output logic         of
);
  always_ff @(posedge clk) begin
    if (rst) begin
      zf <= 1'b1;
      sf <= 1'b0;
      of <= 1'b0;
    end else if (upd) begin
      zf <= ~|res;
      sf <= res[W-1];
      of <= arith & ovf_raw;
    end
  end

  p_flags_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable({zf, sf, of}));

  p_reset_vals_r9: assert property (@(posedge clk)
    rst |=> (zf && !sf && !of));

  p_logic_no_ovf_r7: assert property (@(posedge clk) disable iff (rst)
    (upd && !arith) |=> !of);
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         alu_en,
  input  logic [1:0]   fn_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] result,
  output logic         flag_z,
  output logic         flag_s,
  output logic         flag_o
);
  alu_fn_e      fn;
  logic         is_sub;
  logic         is_arith;
  logic [W-1:0] add_sum;
  logic         add_ovf;

  assign fn       = alu_fn_e'(fn_sel);
  assign is_sub   = (fn == FN_SUB);
  assign is_arith = (fn == FN_ADD) || (fn == FN_SUB);

  flag_alu_adder #(.W(W)) u_adder (
    .a_in (opnd_a),
    .b_in (opnd_b),
    .sub  (is_sub),
    .sum  (add_sum),
    .ovf  (add_ovf)
  );

  always_comb begin
    unique case (fn)
      FN_ADD, FN_SUB: result = add_sum;
      FN_AND:         result = opnd_b & opnd_a;
      FN_XOR:         result = opnd_b ^ opnd_a;
      default:        result = add_sum;
    endcase
  end

  flag_alu_flags #(.W(W)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .upd     (alu_en),
    .arith   (is_arith),
    .ovf_raw (add_ovf),
    .res     (result),
    .zf      (flag_z),
    .sf      (flag_s),
    .of      (flag_o)
  );

  p_add_sum_r1: assert property (@(posedge clk) disable iff (rst)
    (fn_sel == 2'b00) |-> (result - opnd_a == opnd_b));

  p_sub_diff_r2: assert property (@(posedge clk) disable iff (rst)
    (fn_sel == 2'b01) |-> (result + opnd_a == opnd_b));

  p_zero_flag_r4: assert property (@(posedge clk) disable iff (rst)
    alu_en |=> (flag_z == ($past(result) == '0)));

  p_sign_flag_r5: assert property (@(posedge clk) disable iff (rst)
    alu_en |=> (flag_s == $past(result[W-1])));

  p_add_ovf_r6: assert property (@(posedge clk) disable iff (rst)
    (alu_en && fn_sel == 2'b00) |=>
      (flag_o == (($past(opnd_a[W-1]) == $past(opnd_b[W-1])) &&
                  ($past(result[W-1]) != $past(opnd_b[W-1])))));

  p_sub_ovf_r6: assert property (@(posedge clk) disable iff (rst)
    (alu_en && fn_sel == 2'b01) |=>
      (flag_o == (($past(opnd_a[W-1]) != $past(opnd_b[W-1])) &&
                  ($past(result[W-1]) != $past(opnd_b[W-1])))));
endmodule

// File: tb/flag_alu_test.sv
module flag_alu_test;
  localparam int  W      = 64;
  localparam time PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst;
  logic         alu_en;
  logic [1:0]   fn_sel;
  logic [W-1:0] opnd_a;
  logic [W-1:0] opnd_b;
  logic [W-1:0] result;
  logic         flag_z, flag_s, flag_o;

  int checks = 0;
  int errors = 0;
  logic [2:0] exp_flags;

  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};

  always #(PERIOD/2) clk = ~clk;

  flag_alu uut (
    .clk(clk), .rst(rst), .alu_en(alu_en), .fn_sel(fn_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o)
  );

  function automatic logic [W-1:0] model_res(input logic [1:0] f,
                                              input logic [W-1:0] a,
                                              input logic [W-1:0] b);
    case (f)
      2'b00:   return b + a;
      2'b01:   return b - a;
      2'b10:   return b & a;
      default: return b ^ a;
    endcase
  endfunction

  // signed overflow from operand and result signs
  function automatic logic model_ovf(input logic [1:0] f,
                                     input logic [W-1:0] a,
                                     input logic [W-1:0] b);
    logic [W-1:0] r;
    r = model_res(f, a, b);
    case (f)
      2'b00:   return (a[W-1] == b[W-1]) && (r[W-1] != b[W-1]);
      2'b01:   return (a[W-1] != b[W-1]) && (r[W-1] != b[W-1]);
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag);
    chk({tag, " flag_z R4"}, {{(W-1){1'b0}}, flag_z}, {{(W-1){1'b0}}, exp_flags[2]});
    chk({tag, " flag_s R5"}, {{(W-1){1'b0}}, flag_s}, {{(W-1){1'b0}}, exp_flags[1]});
    chk({tag, " flag_o R6/R7"}, {{(W-1){1'b0}}, flag_o}, {{(W-1){1'b0}}, exp_flags[0]});
  endtask

  task automatic run_op(input logic [1:0] f, input logic [W-1:0] a,
                        input logic [W-1:0] b, input string tag);
    logic [W-1:0] r;
    @(negedge clk);
    fn_sel = f; opnd_a = a; opnd_b = b; alu_en = 1'b1;
    #1;
    r = model_res(f, a, b);
    chk({tag, (f == 2'b00) ? " R1" : (f == 2'b01) ? " R2" : " R3"}, result, r);
    chk_flags({tag, " pre-edge R10"});
    exp_flags = {(r == '0), r[W-1], model_ovf(f, a, b)};
    @(negedge clk);
    chk_flags(tag);
    alu_en = 1'b0;
  endtask

  task automatic idle_op(input logic [1:0] f, input logic [W-1:0] a,
                         input logic [W-1:0] b, input string tag);
    @(negedge clk);
    fn_sel = f; opnd_a = a; opnd_b = b; alu_en = 1'b0;
    @(negedge clk);
    chk_flags({tag, " hold R8"});
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++; checks++;
    $display("FAIL R10 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; alu_en = 1'b0; fn_sel = 2'b00; opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    exp_flags = 3'b100;
    chk_flags("reset R9");
    rst = 1'b0;

    // directed corner cases
    run_op(2'b00, 64'd1, MAXP, "maxpos+1");
    idle_op(2'b10, '0, '0, "after maxpos+1");
    run_op(2'b01, 64'd1, MINN, "minneg-1");
    run_op(2'b01, MINN, '0, "0-minneg");
    run_op(2'b00, 64'd1, '1, "-1+1 carry no ovf");
    run_op(2'b01, 64'h1234, 64'h1234, "equal sub");
    run_op(2'b01, 64'd5, 64'd3, "3-5");
    idle_op(2'b00, MAXP, MAXP, "after 3-5");
    run_op(2'b00, MINN, MINN, "minneg+minneg");
    run_op(2'b10, 64'hF0F0, 64'h0F0F, "and disjoint");
    run_op(2'b11, '1, '1, "xor same");
    run_op(2'b11, MINN, 64'd0, "xor sign");
    run_op(2'b01, MINN, MAXP, "maxpos-minneg");
    run_op(2'b10, MAXP, MINN, "and after ovf");

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [1:0] f;
      logic [W-1:0] a, b;
      f = 2'($urandom_range(0, 3));
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if ((i % 7) == 0) a = b;
      if ((i % 11) == 0) b = ~a;
      if ((i % 5) == 0) idle_op(f, a, b, "rand idle");
      else run_op(f, a, b, "rand");
    end

    // reset priority over strobe
    run_op(2'b00, 64'd1, MAXP, "pre-reset ovf");
    @(negedge clk);
    rst = 1'b1; alu_en = 1'b1; fn_sel = 2'b00; opnd_a = '1; opnd_b = '1;
    @(negedge clk);
    exp_flags = 3'b100;
    chk_flags("reset over strobe R9");
    rst = 1'b0; alu_en = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule